// File: doc/BRIEF.md
# System-Error Interrupt Aggregator

This block collects 64 error interrupt sources into a single summary line for an upstream interrupt controller. The lower 21 sources come from wired inputs that are active-high and level-sensitive. The upper 43 sources have no wires. Each one is raised by a message-signalled write: software or a remote agent writes a source number to a doorbell register, and that write sets the source's pending bit once.

Every source has a pending (cause) bit and a disable (mask) bit. Both are held in two 32-bit registers, and source n lives in register n/32 at bit n%32. Software reads the cause registers to find pending sources. It acknowledges a source by writing 1 to its cause bit, and it enables or disables sources through the mask registers. The summary output is high while any cause bit is set and its mask bit is 0. A plain register bus gives access: byte address, write data, write strobe and combinational read data.

Top module: `err_irq_aggregator`

## Requirements
- R1: After reset, both cause registers read 0x00000000, both mask registers read 0xFFFFFFFF, and `irqOut` is low.
- R2: A wired input n (0..20) that is high at a clock edge sets cause bit n, and the bit is visible from the following cycle.
- R3: A write to cause register k (offset 0x00 + 4k) clears each cause bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: When a set and a write-1-to-clear hit the same cause bit in the same cycle, the bit stays set. A wired input that is still high therefore re-sets its bit.
- R5: A write to mask register k (offset 0x20 + 4k) loads all 32 mask bits. A mask bit of 1 disables its source and a bit of 0 enables it.
- R6: A write of value v in 21..63 to the doorbell offset 0x30 sets cause bit v, which is register v/32, bit v%32.
- R7: A doorbell write with a value below 21 or above 63 changes no cause bit.
- R8: `irqOut` is high exactly while some cause bit is 1 and its mask bit is 0.
- R9: A read of the doorbell offset, or of any unmapped offset, returns zero.
- R10: Cause bits read back their pending state whatever the mask setting. Masking affects only `irqOut`.
- R11: A cause bit set by a wired input stays set after the input falls, until a write-1-to-clear removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one write per cycle high |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| wiredIn | input | 21 | Level-sensitive error inputs for sources 0..20 |
| irqOut | output | 1 | Summary interrupt to the upstream controller |

## Verification
Two things can hit the same cause bit in one cycle: a set from a wired level input and a write-1-to-clear from the bus. The bench holds a wired input high and writes a clear mask that covers that bit. It then reads the cause register to confirm the bit is still pending, drops the input and clears again. The random phase mixes random wired patterns with random clear masks, so many more same-cycle collisions come up. Each readback is judged against a bench model in which set takes precedence over clear.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  localparam int SRC_COUNT = 64;
  localparam int REG_W     = 32;
  localparam int REG_COUNT = SRC_COUNT / REG_W;
  localparam int IDX_W     = $clog2(SRC_COUNT);
  localparam int REGSEL_W  = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  localparam int CAUSE_BASE   = 'h00;
  localparam int MASK_BASE    = 'h20;
  localparam int DOORBELL_OFS = 'h30;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2
  } rdKind_e;

  typedef struct packed {
    logic [REG_COUNT-1:0] clrWr;
    logic [REG_COUNT-1:0] maskWr;
    logic                 dbValid;
    logic [IDX_W-1:0]     dbIdx;
    rdKind_e              rdKind;
    logic [REGSEL_W-1:0]  rdIdx;
  } aggStrobe_t;
endpackage

// File: rtl/err_agg_ctrl.sv
module err_agg_ctrl
  import err_agg_pkg::*;
#(
  parameter int WIRED_COUNT = 21,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWrEn,
  output aggStrobe_t        strobe
);
  logic dbHit;
  logic dbInRange;

  assign dbHit     = busWrEn && (busAddr == ADDR_W'(DOORBELL_OFS));
  assign dbInRange = (busWdata >= REG_W'(WIRED_COUNT)) && (busWdata < REG_W'(SRC_COUNT));

  always_comb begin
    strobe        = '0;
    strobe.rdKind = RD_NONE;
    for (int r = 0; r < REG_COUNT; r++) begin
      if (busAddr == ADDR_W'(CAUSE_BASE + 4 * r)) begin
        strobe.rdKind   = RD_CAUSE;
        strobe.rdIdx    = REGSEL_W'(r);
        strobe.clrWr[r] = busWrEn;
      end
      if (busAddr == ADDR_W'(MASK_BASE + 4 * r)) begin
        strobe.rdKind    = RD_MASK;
        strobe.rdIdx     = REGSEL_W'(r);
        strobe.maskWr[r] = busWrEn;
      end
    end
    if (dbHit && dbInRange) begin
      strobe.dbValid = 1'b1;
      strobe.dbIdx   = busWdata[IDX_W-1:0];
    end
  end

  // R7
  db_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dbHit && !dbInRange) |-> !strobe.dbValid);

  // R6
  db_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (dbHit && dbInRange) |-> (strobe.dbValid && (REG_W'(strobe.dbIdx) == busWdata)));
endmodule

// File: rtl/err_agg_datapath.sv
module err_agg_datapath
  import err_agg_pkg::*;
#(
  parameter int WIRED_COUNT = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  aggStrobe_t             strobe,
  input  logic [REG_W-1:0]       busWdata,
  input  logic [WIRED_COUNT-1:0] wiredIn,
  output logic [REG_W-1:0]       busRdata,
  output logic                   irqOut
);
  logic [SRC_COUNT-1:0] setVec;
  logic [SRC_COUNT-1:0] clrVec;
  logic [SRC_COUNT-1:0] causeQ;
  logic [SRC_COUNT-1:0] causeD;
  logic [SRC_COUNT-1:0] maskQ;
  logic [SRC_COUNT-1:0] wiredPad;

  assign wiredPad = SRC_COUNT'(wiredIn);

  for (genvar n = 0; n < SRC_COUNT; n++) begin : g_set
    if (n < WIRED_COUNT) begin : g_wired
      assign setVec[n] = wiredIn[n];
    end else begin : g_msg
      assign setVec[n] = strobe.dbValid && (strobe.dbIdx == IDX_W'(n));
    end
  end

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_clr
    assign clrVec[r*REG_W +: REG_W] = strobe.clrWr[r] ? busWdata : '0;
  end

  // set has priority over a same-cycle clear
  assign causeD = setVec | (causeQ & ~clrVec);

  always_ff @(posedge clk) begin
    if (rst) begin
      causeQ <= '0;
      maskQ  <= '1;
    end else begin
      causeQ <= causeD;
      for (int r = 0; r < REG_COUNT; r++) begin
        if (strobe.maskWr[r]) maskQ[r*REG_W +: REG_W] <= busWdata;
      end
    end
  end

  assign irqOut = |(causeQ & ~maskQ);

  always_comb begin
    case (strobe.rdKind)
      RD_CAUSE: busRdata = causeQ[int'(strobe.rdIdx)*REG_W +: REG_W];
      RD_MASK:  busRdata = maskQ[int'(strobe.rdIdx)*REG_W +: REG_W];
      default:  busRdata = '0;
    endcase
  end

  // R2
  wired_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (wiredIn != '0) |=> ((causeQ[WIRED_COUNT-1:0] & $past(wiredIn)) == $past(wiredIn)));

  // R6
  doorbell_set_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.dbValid |=> causeQ[$past(strobe.dbIdx)]);

  // R7
  msg_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((causeQ[SRC_COUNT-1:WIRED_COUNT] & ~$past(causeQ[SRC_COUNT-1:WIRED_COUNT])) != '0)
      |-> $past(strobe.dbValid));

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (&maskQ) |-> !irqOut);

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_chk
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.clrWr[r] |=> ((causeQ[r*REG_W +: REG_W] & $past(busWdata)
                            & ~$past(wiredPad[r*REG_W +: REG_W])) == '0));
    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.maskWr[r] |=> (maskQ[r*REG_W +: REG_W] == $past(busWdata)));
  end
endmodule

// File: rtl/err_irq_aggregator.sv
module err_irq_aggregator
  import err_agg_pkg::*;
#(
  parameter int WIRED_COUNT = 21,
  parameter int ADDR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [REG_W-1:0]       busWdata,
  input  logic                   busWrEn,
  output logic [REG_W-1:0]       busRdata,
  input  logic [WIRED_COUNT-1:0] wiredIn,
  output logic                   irqOut
);
  aggStrobe_t strobe;

  err_agg_ctrl #(
    .WIRED_COUNT(WIRED_COUNT),
    .ADDR_W     (ADDR_W)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  err_agg_datapath #(
    .WIRED_COUNT(WIRED_COUNT)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .busWdata(busWdata),
    .wiredIn (wiredIn),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/test_err_irq_aggregator.sv
module test_err_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic        busWrEn;
  logic [31:0] busRdata;
  logic [20:0] wiredIn;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] expCause;
  logic [63:0] expMask;

  always #2 clk = ~clk;

  err_irq_aggregator i_err_irq_aggregator (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata),
    .busWrEn(busWrEn), .busRdata(busRdata), .wiredIn(wiredIn), .irqOut(irqOut)
  );

  function automatic logic [63:0] nextCause(input logic [63:0] c, input logic [20:0] w,
                                            input logic we, input logic [7:0] a,
                                            input logic [31:0] d);
    logic [63:0] s;
    logic [63:0] clr;
    s = 64'(w);
    clr = '0;
    if (we) begin
      if (a == 8'h00) clr[31:0]  = d;
      if (a == 8'h04) clr[63:32] = d;
      if (a == 8'h30 && d >= 32'd21 && d <= 32'd63) s[d[5:0]] = 1'b1;
    end
    return s | (c & ~clr);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00:   return expCause[31:0];
      8'h04:   return expCause[63:32];
      8'h20:   return expMask[31:0];
      8'h24:   return expMask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expCause <= '0;
      expMask  <= '1;
    end else begin
      expCause <= nextCause(expCause, wiredIn, busWrEn, busAddr, busWdata);
      if (busWrEn && busAddr == 8'h20) expMask[31:0]  <= busWdata;
      if (busWrEn && busAddr == 8'h24) expMask[63:32] <= busWdata;
    end
  end

  task automatic checkVal(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic readCheck(input logic [7:0] a, input string tag);
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = a;
    #1;
    checkVal(tag, busRdata, expRead(a));
  endtask

  task automatic irqCheck(input string tag);
    checkVal(tag, 32'(irqOut), 32'(|(expCause & ~expMask)));
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr  = a;
    busWdata = d;
    busWrEn  = 1'b1;
    @(negedge clk);
    busWrEn  = 1'b0;
  endtask

  task automatic setWired(input logic [20:0] w);
    @(negedge clk);
    busWrEn = 1'b0;
    wiredIn = w;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap0;
    logic [31:0] snap1;
    void'($urandom(32'd1234));
    rst = 1'b1; busAddr = '0; busWdata = '0; busWrEn = 1'b0; wiredIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk); #1;
    checkVal("R1 cause0", i_err_irq_aggregator.busRdata, 32'h0);
    readCheck(8'h04, "R1 cause1");
    readCheck(8'h20, "R1 mask0");
    checkVal("R1 mask0 literal", busRdata, 32'hFFFF_FFFF);
    readCheck(8'h24, "R1 mask1");
    checkVal("R1 irq", 32'(irqOut), 32'h0);

    // R2 and R11: level capture, held after input falls
    setWired(21'h20);
    setWired(21'h0);
    readCheck(8'h00, "R2 R11 cause0");
    checkVal("R11 bit5 held", busRdata, 32'h20);

    // R5 and R8: unmask bit 5
    busWrite(8'h20, ~32'h20);
    readCheck(8'h20, "R5 mask0");
    checkVal("R8 irq high", 32'(irqOut), 32'h1);

    // R3: write-1-to-clear, zeros leave bits alone
    setWired(21'h1);
    setWired(21'h0);
    busWrite(8'h00, 32'h20);
    readCheck(8'h00, "R3 cause0");
    checkVal("R3 bit0 kept", busRdata, 32'h1);
    irqCheck("R8 irq after clear");

    // R4: same-cycle set and clear, set wins
    setWired(21'h8);
    busWrite(8'h00, 32'h9);
    readCheck(8'h00, "R4 cause0");
    checkVal("R4 bit3 kept", busRdata, 32'h8);
    setWired(21'h0);
    busWrite(8'h00, 32'h8);
    readCheck(8'h00, "R4 cleared after fall");

    // R6: doorbell writes
    busWrite(8'h30, 32'd40);
    busWrite(8'h30, 32'd21);
    busWrite(8'h30, 32'd63);
    readCheck(8'h04, "R6 cause1");
    checkVal("R6 bits 40,63", busRdata, 32'h8000_0100);
    readCheck(8'h00, "R6 cause0 bit21");

    // R7: out-of-range doorbell values
    readCheck(8'h00, "R7 snap0"); snap0 = busRdata;
    readCheck(8'h04, "R7 snap1"); snap1 = busRdata;
    busWrite(8'h30, 32'd20);
    busWrite(8'h30, 32'd64);
    busWrite(8'h30, 32'hFFFF_FFFF);
    busWrite(8'h30, 32'd0);
    readCheck(8'h00, "R7 cause0");
    checkVal("R7 cause0 unchanged", busRdata, snap0);
    readCheck(8'h04, "R7 cause1");
    checkVal("R7 cause1 unchanged", busRdata, snap1);

    // R9: doorbell and unmapped reads
    readCheck(8'h30, "R9 doorbell read");
    checkVal("R9 zero", busRdata, 32'h0);
    readCheck(8'h14, "R9 unmapped read");

    // R10: cause visible while fully masked
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h24, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h30, 32'd50);
    readCheck(8'h04, "R10 cause1 masked");
    checkVal("R10 bit50", busRdata, 32'h0004_0000);
    checkVal("R10 irq low", 32'(irqOut), 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: setWired(($urandom_range(0, 3) == 0) ? 21'($urandom) : 21'h0);
        1: busWrite(($urandom_range(0, 1) == 0) ? 8'h00 : 8'h04, $urandom);
        2: busWrite(($urandom_range(0, 1) == 0) ? 8'h20 : 8'h24, $urandom);
        3: busWrite(8'h30, 32'($urandom_range(0, 70)));
        4: busWrite(8'h30, 32'($urandom_range(21, 63)));
        default: begin
          @(negedge clk);
          busWrEn = 1'b0;
        end
      endcase
      case ($urandom_range(0, 4))
        0: readCheck(8'h00, "R2 R3 R4 rand cause0");
        1: readCheck(8'h04, "R6 R7 rand cause1");
        2: readCheck(8'h20, "R5 rand mask0");
        3: readCheck(8'h24, "R5 rand mask1");
        default: readCheck(8'h30, "R9 rand doorbell");
      endcase
      irqCheck("R8 R10 rand irq");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule